// File: doc/BRIEF.md
# Bus Cycle Timeout Watchdog

This block guards every I/O or memory access cycle on a processor bus. When a cycle begins, it starts counting rising edges of a slow, free-running timer tick. If the normal ready handshake has still not come back when the second counted edge arrives, the watchdog ends the stalled cycle itself. It does this by pulling a forced-ready line low. It also emits a one-clock report pulse that says whether the stalled access was I/O or memory, so that a separate fault register can set the matching bit.

The tick is sampled rather than synchronised to the cycle start. The real timeout is therefore at least one and at most two tick periods. When the bus is handed to a DMA master (pause low) or the processor is held (hold acknowledge low), the watchdog is forced back to idle and stays inactive. The tick passes through a synchroniser of parameterised depth, so it may come from an unrelated clock.

Top module: `bus_cycle_watchdog`

## Requirements
- R1: With the default two synchroniser stages, a tick rising edge counts at the third system clock edge after `tick_in` rises. A count occurs only while a cycle is waiting for ready. If `rdy_n` is still high at the counting edge of the second such tick, `force_rdy_n` goes low at that same clock edge.
- R2: A single counted tick never causes a timeout, however long the cycle then waits without ready.
- R3: `is_mem` is captured at the first clock edge where `cyc_act` is high, with 1 meaning memory and 0 meaning I/O. A timeout in an I/O cycle pulses `to_io_p`, and a timeout in a memory cycle pulses `to_mem_p`.
- R4: Each timeout produces exactly one report pulse, one system clock long. `to_io_p` and `to_mem_p` are never high together.
- R5: If `rdy_n` is low at or before the clock edge that would expire the cycle, the cycle succeeds. This includes the expiry edge itself. A successful cycle gives no forced ready and no report pulse.
- R6: After a timeout, `force_rdy_n` stays low until `cyc_act` is sampled low. It returns high at that clock edge.
- R7: `pause_n` low returns the watchdog to idle, clears its tick count, and releases `force_rdy_n`. While `pause_n` is low, no timeout can occur.
- R8: `hold_ack_n` low has the same reset-and-disable effect as `pause_n` low.
- R9: Tick edges seen while no cycle is active are not counted toward the next cycle.
- R10: While `rst` is high, `force_rdy_n` is high and both report pulses are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_act | input | 1 | High for the duration of an access cycle |
| is_mem | input | 1 | Access type: 1 memory, 0 I/O |
| rdy_n | input | 1 | Normal ready handshake, active low |
| tick_in | input | 1 | Free-running timer tick, any phase |
| pause_n | input | 1 | Low while a DMA master owns the bus |
| hold_ack_n | input | 1 | Low while the processor is held |
| force_rdy_n | output | 1 | Forced ready that ends a stalled cycle, active low |
| to_io_p | output | 1 | One-clock pulse: I/O cycle timed out |
| to_mem_p | output | 1 | One-clock pulse: memory cycle timed out |

## Verification
The bench asserts ready on the very clock edge that would expire the cycle. If a design lets expiry beat ready there, it reports a spurious fault. It also asserts ready one edge later, where an off-by-one design would wrongly accept it. A single tick is followed by a long wait, to catch a design that expires on the first edge. A tick is also sent just before the cycle starts, to catch a design that counts idle ticks. A brief pause or hold pulse is placed in the middle of a cycle. A design that freezes the count instead of clearing it would then time out one tick early. Forced-ready release is tested against both the end of the cycle and a hold arriving while the cycle is forced, because a design that latches the forced state would leave the bus stuck.

// File: rtl/wd_pkg.sv
package wd_pkg;
  typedef enum logic [1:0] {
    WD_IDLE   = 2'd0,
    WD_WAIT   = 2'd1,
    WD_DONE   = 2'd2,
    WD_FORCED = 2'd3
  } wd_state_e;

  typedef enum logic {
    ACC_IO  = 1'b0,
    ACC_MEM = 1'b1
  } acc_kind_e;
endpackage

// File: rtl/wd_tick_sync.sv
module wd_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_in,
  output logic tick_rise
);
  logic tick_s;
  logic prev_q;

  generate
    if (STAGES == 0) begin : g_direct
      assign tick_s = tick_in;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else if (STAGES == 1) chain_q <= tick_in;
        else chain_q <= {chain_q[STAGES-2:0], tick_in};
      end
      assign tick_s = chain_q[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= tick_s;
  end

  assign tick_rise = tick_s & ~prev_q;
endmodule

// File: rtl/wd_cycle_timer.sv
module wd_cycle_timer
  import wd_pkg::*;
#(
  parameter int EXPIRE_EDGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      enable,
  input  logic      cyc_act,
  input  logic      is_mem,
  input  logic      rdy_n,
  input  logic      tick_rise,
  output logic      expire_now,
  output acc_kind_e kind
);
  localparam int CNT_W = (EXPIRE_EDGES > 1) ? $clog2(EXPIRE_EDGES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(EXPIRE_EDGES - 1);

  wd_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  acc_kind_e        kind_q;

  // Ready is tested before the tick, so ready on the expiry edge wins.
  assign expire_now = enable && cyc_act && (state_q == WD_WAIT) &&
                      rdy_n && tick_rise && (cnt_q == LAST);
  assign kind = kind_q;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      state_q <= WD_IDLE;
      cnt_q   <= '0;
      if (rst) kind_q <= ACC_IO;
    end else begin
      unique case (state_q)
        WD_IDLE: begin
          cnt_q <= '0;
          if (cyc_act) begin
            state_q <= WD_WAIT;
            kind_q  <= is_mem ? ACC_MEM : ACC_IO;
          end
        end
        WD_WAIT: begin
          if (!cyc_act)      state_q <= WD_IDLE;
          else if (!rdy_n)   state_q <= WD_DONE;
          else if (tick_rise) begin
            if (cnt_q == LAST) state_q <= WD_FORCED;
            else               cnt_q   <= cnt_q + 1'b1;
          end
        end
        default: begin
          if (!cyc_act) state_q <= WD_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/wd_out_stage.sv
module wd_out_stage
  import wd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      enable,
  input  logic      cyc_act,
  input  logic      expire_now,
  input  acc_kind_e kind,
  output logic      force_rdy_n,
  output logic      to_io_p,
  output logic      to_mem_p
);
  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      force_rdy_n <= 1'b1;
      to_io_p     <= 1'b0;
      to_mem_p    <= 1'b0;
    end else begin
      to_io_p  <= expire_now && (kind == ACC_IO);
      to_mem_p <= expire_now && (kind == ACC_MEM);
      if (expire_now)    force_rdy_n <= 1'b0;
      else if (!cyc_act) force_rdy_n <= 1'b1;
    end
  end
endmodule

// File: rtl/bus_cycle_watchdog.sv
module bus_cycle_watchdog
  import wd_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int EXPIRE_EDGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cyc_act,
  input  logic is_mem,
  input  logic rdy_n,
  input  logic tick_in,
  input  logic pause_n,
  input  logic hold_ack_n,
  output logic force_rdy_n,
  output logic to_io_p,
  output logic to_mem_p
);
  logic      enable;
  logic      tick_rise;
  logic      expire_now;
  acc_kind_e kind;

  assign enable = pause_n & hold_ack_n;

  wd_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .tick_in   (tick_in),
    .tick_rise (tick_rise)
  );

  wd_cycle_timer #(.EXPIRE_EDGES(EXPIRE_EDGES)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .cyc_act    (cyc_act),
    .is_mem     (is_mem),
    .rdy_n      (rdy_n),
    .tick_rise  (tick_rise),
    .expire_now (expire_now),
    .kind       (kind)
  );

  wd_out_stage u_out (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .cyc_act     (cyc_act),
    .expire_now  (expire_now),
    .kind        (kind),
    .force_rdy_n (force_rdy_n),
    .to_io_p     (to_io_p),
    .to_mem_p    (to_mem_p)
  );
endmodule

// File: rtl/wd_checker.sv
module wd_checker (
  input logic clk,
  input logic rst,
  input logic cyc_act,
  input logic rdy_n,
  input logic pause_n,
  input logic hold_ack_n,
  input logic force_rdy_n,
  input logic to_io_p,
  input logic to_mem_p
);
  a_r1_force_with_report: assert property (@(posedge clk) disable iff (rst)
    $fell(force_rdy_n) |-> (to_io_p || to_mem_p));

  a_r4_pulse_one_clock: assert property (@(posedge clk) disable iff (rst)
    (to_io_p || to_mem_p) |=> !(to_io_p || to_mem_p));

  a_r4_pulse_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(to_io_p && to_mem_p));

  a_r5_ready_prevents: assert property (@(posedge clk) disable iff (rst)
    ($rose(to_io_p) || $rose(to_mem_p)) |-> $past(rdy_n));

  a_r6_release_on_end: assert property (@(posedge clk) disable iff (rst)
    !cyc_act |=> force_rdy_n);

  a_r7_pause_disables: assert property (@(posedge clk) disable iff (rst)
    !pause_n |=> (force_rdy_n && !to_io_p && !to_mem_p));

  a_r8_hold_disables: assert property (@(posedge clk) disable iff (rst)
    !hold_ack_n |=> (force_rdy_n && !to_io_p && !to_mem_p));
endmodule

bind bus_cycle_watchdog wd_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .cyc_act     (cyc_act),
  .rdy_n       (rdy_n),
  .pause_n     (pause_n),
  .hold_ack_n  (hold_ack_n),
  .force_rdy_n (force_rdy_n),
  .to_io_p     (to_io_p),
  .to_mem_p    (to_mem_p)
);

// File: tb/tb_bus_cycle_watchdog.sv
`timescale 1ns/1ps
module tb_bus_cycle_watchdog;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_act = 1'b0, is_mem = 1'b0, rdy_n = 1'b1, tick_in = 1'b0;
  logic pause_n = 1'b1, hold_ack_n = 1'b1;
  logic force_rdy_n, to_io_p, to_mem_p;

  int n_chk = 0, n_fail = 0;
  int io_cnt, mem_cnt;

  always #2.5 clk = ~clk;

  bus_cycle_watchdog dut (
    .clk(clk), .rst(rst), .cyc_act(cyc_act), .is_mem(is_mem), .rdy_n(rdy_n),
    .tick_in(tick_in), .pause_n(pause_n), .hold_ack_n(hold_ack_n),
    .force_rdy_n(force_rdy_n), .to_io_p(to_io_p), .to_mem_p(to_mem_p)
  );

  // Vector: {is_mem, rdy_tick (3 = never), rdy_step, expect_timeout}
  localparam logic [6:0] VECS [0:5] = '{
    {1'b0, 2'd3, 3'd0, 1'b1},
    {1'b1, 2'd3, 3'd0, 1'b1},
    {1'b0, 2'd0, 3'd0, 1'b0},
    {1'b1, 2'd1, 3'd2, 1'b0},
    {1'b0, 2'd1, 3'd3, 1'b1},
    {1'b1, 2'd1, 3'd0, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // One tick of five clocks; the rise is counted at the third edge.
  task automatic run_tick(input int idx, input int rdy_tick, input int rdy_step);
    for (int s = 0; s < 5; s++) begin
      tick_in = (s < 2);
      if (idx == rdy_tick && s == rdy_step) rdy_n = 1'b0;
      step();
      io_cnt  += int'(to_io_p);
      mem_cnt += int'(to_mem_p);
    end
  endtask

  task automatic start_cycle(input logic m);
    cyc_act = 1'b1; is_mem = m; rdy_n = 1'b1;
    io_cnt = 0; mem_cnt = 0;
    step();
  endtask

  task automatic end_cycle(input string req);
    cyc_act = 1'b0; rdy_n = 1'b1;
    step();
    chk(force_rdy_n == 1'b1, req, force_rdy_n, 1);
    step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
    summary();
  end

  initial begin
    // R10 reset state
    repeat (3) step();
    chk(force_rdy_n == 1'b1, "R10 force_rdy_n", force_rdy_n, 1);
    chk(!to_io_p && !to_mem_p, "R10 pulses", {to_io_p, to_mem_p}, 0);
    rst = 1'b0;
    step();

    // Vector walk: R1, R3, R4, R5, R6
    for (int v = 0; v < 6; v++) begin
      logic m, e;
      int rt, rs;
      m  = VECS[v][6];
      rt = int'(VECS[v][5:4]);
      rs = int'(VECS[v][3:1]);
      e  = VECS[v][0];
      start_cycle(m);
      run_tick(0, rt, rs);
      run_tick(1, rt, rs);
      chk(io_cnt == ((e && !m) ? 1 : 0), "R3/R4 io pulse count", io_cnt, (e && !m) ? 1 : 0);
      chk(mem_cnt == ((e && m) ? 1 : 0), "R3/R4 mem pulse count", mem_cnt, (e && m) ? 1 : 0);
      chk(force_rdy_n == !e, "R1/R5 force_rdy_n", force_rdy_n, int'(!e));
      repeat (4) step();
      chk(force_rdy_n == !e, "R6 force held", force_rdy_n, int'(!e));
      end_cycle("R6 release");
    end

    // R2: one tick then a long wait
    start_cycle(1'b0);
    run_tick(0, 3, 0);
    repeat (30) begin
      step();
      io_cnt += int'(to_io_p);
    end
    chk(force_rdy_n == 1'b1 && io_cnt == 0, "R2 single tick", io_cnt, 0);
    end_cycle("R2 end");

    // R9: tick while idle is not counted
    io_cnt = 0;
    run_tick(0, 3, 0);
    start_cycle(1'b0);
    run_tick(0, 3, 0);
    chk(io_cnt == 0 && force_rdy_n, "R9 idle tick ignored", io_cnt, 0);
    run_tick(1, 3, 0);
    chk(io_cnt == 1, "R9 second in-cycle tick expires", io_cnt, 1);
    end_cycle("R9 end");

    // R7: short pause mid-cycle clears the count
    start_cycle(1'b1);
    run_tick(0, 3, 0);
    pause_n = 1'b0; step(); pause_n = 1'b1;
    run_tick(0, 3, 0);
    chk(mem_cnt == 0 && force_rdy_n, "R7 pause clears count", mem_cnt, 0);
    run_tick(1, 3, 0);
    chk(mem_cnt == 1, "R7 count restarts after pause", mem_cnt, 1);
    end_cycle("R7 end");

    // R7: pause held over several ticks
    pause_n = 1'b0;
    start_cycle(1'b0);
    run_tick(0, 3, 0); run_tick(1, 3, 0); run_tick(2, 3, 0);
    chk(io_cnt == 0 && force_rdy_n, "R7 pause held", io_cnt, 0);
    cyc_act = 1'b0; step(); pause_n = 1'b1; step();

    // R8: hold ack releases a forced cycle and blocks timeouts
    start_cycle(1'b1);
    run_tick(0, 3, 0); run_tick(1, 3, 0);
    chk(force_rdy_n == 1'b0, "R8 precondition forced", force_rdy_n, 0);
    hold_ack_n = 1'b0; step();
    chk(force_rdy_n == 1'b1, "R8 hold releases force", force_rdy_n, 1);
    mem_cnt = 0;
    run_tick(0, 3, 0); run_tick(1, 3, 0);
    chk(mem_cnt == 0 && force_rdy_n, "R8 hold blocks timeout", mem_cnt, 0);
    cyc_act = 1'b0; step(); hold_ack_n = 1'b1; step();

    // R8: short hold mid-cycle clears the count
    start_cycle(1'b0);
    run_tick(0, 3, 0);
    hold_ack_n = 1'b0; step(); hold_ack_n = 1'b1;
    run_tick(0, 3, 0);
    chk(io_cnt == 0 && force_rdy_n, "R8 hold clears count", io_cnt, 0);
    end_cycle("R8 end");

    summary();
  end
endmodule